// File: doc/BRIEF.md
# Asynchronous Memory Bank Enable Decoder

This block is the control front end of an external asynchronous memory controller. It has three registers on a 32-bit register bus. The first is a 16-bit global control word. The other two are 32-bit bank configuration words, which feed the timing logic further down the chip. Software reaches each register by its byte offset. A bad access width or an unknown offset gives an error pulse in the same cycle as the access.

The block also decodes external memory addresses. The external window has four banks of equal size, one after another, starting at a base address. A 3-bit field in the global control word sets how many banks are live, counting up from bank 0, and any value above four counts as four. The chip select of a bank goes high only when the address falls in that bank and the bank is live.

Top module: `amem_bank_ctl`

## Requirements
- R1: After reset the global word reads 0x0000, so no chip select is active. Both bank configuration words read 0xFFC2FFC2.
- R2: The registers sit at these byte offsets: the global word at 0x0, bank configuration 0 at 0x4 and bank configuration 1 at 0x8. A read returns the stored value on reg_rdata in the same cycle.
- R3: Access width uses this encoding on reg_size: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is reserved. The global word accepts only reg_size = 1. Any other width raises reg_err, leaves the register unchanged and reads as zero.
- R4: An access to any offset other than 0x0, 0x4 or 0x8 raises reg_err, reads as zero and changes no register.
- R5: reg_err is high only in a cycle with reg_valid high, and it is combinational with that access.
- R6: The live-bank count is taken from global word bits [3:1]. Values 5, 6 and 7 behave as 4.
- R7: Bank i covers BANK_BASE + i*2^BANK_SHIFT up to the next bank's start minus one. mem_cs is one-hot or zero. It is zero for any address below BANK_BASE or at or above BANK_BASE + 4*2^BANK_SHIFT.
- R8: mem_cs[i] asserts only when i is below the live-bank count. A new count takes effect in the cycle after the write edge.
- R9: A write to a bank configuration word stores all 32 bits of reg_wdata whatever the width. A read returns all 32 bits, and the new value appears on bank_cfg0/bank_cfg1 after the write edge.
- R10: A global word write stores reg_wdata[15:0]. A read returns that value zero-extended, and glb_ctl shows it after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access present this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_size | input | 2 | Access width code |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle |
| reg_err | output | 1 | Access error, same cycle |
| mem_addr | input | 32 | External memory address to decode |
| mem_cs | output | 4 | Per-bank chip selects |
| glb_ctl | output | 16 | Global control word |
| bank_cfg0 | output | 32 | Bank configuration word 0 |
| bank_cfg1 | output | 32 | Bank configuration word 1 |

## Verification
reg_rdata and reg_err respond in the same cycle as the access, with no added cycles. The bench drives each access after a falling edge and samples both outputs one nanosecond later, before the rising edge that commits it. Register contents, glb_ctl and the bank configuration outputs change at that rising edge. The bench therefore checks them only on a later access, or after the following falling edge. mem_cs depends only on the address and on the registered count, so each address probe is sampled shortly after it is applied. Every count change is probed one cycle after its write.

// File: rtl/amem_pkg.sv
package amem_pkg;
    localparam int DATA_W = 32;
    localparam int GCTL_W = 16;
    localparam int CNT_W  = 3;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [DATA_W-1:0] CFG_RESET = 32'hFFC2_FFC2;

    typedef struct packed {
        logic [GCTL_W-1:0] gctl;
        logic [DATA_W-1:0] cfg0;
        logic [DATA_W-1:0] cfg1;
    } ctl_state_t;
endpackage

// File: rtl/amem_regfile.sv
module amem_regfile
    import amem_pkg::*;
#(
    parameter int REG_AW    = 8,
    parameter int NUM_BANKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_err,
    output logic [CNT_W-1:0]  en_cnt,
    output logic [GCTL_W-1:0] gctl_o,
    output logic [DATA_W-1:0] cfg0_o,
    output logic [DATA_W-1:0] cfg1_o
);
    localparam logic [REG_AW-1:0] OFF_GCTL = REG_AW'(0);
    localparam logic [REG_AW-1:0] OFF_CFG0 = REG_AW'(4);
    localparam logic [REG_AW-1:0] OFF_CFG1 = REG_AW'(8);
    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(NUM_BANKS);

    ctl_state_t st_d, st_q;
    logic       sel_g, sel_0, sel_1;
    logic [CNT_W-1:0] field_q;

    assign sel_g = (reg_addr == OFF_GCTL);
    assign sel_0 = (reg_addr == OFF_CFG0);
    assign sel_1 = (reg_addr == OFF_CFG1);

    always_comb begin
        st_d      = st_q;
        reg_rdata = '0;
        reg_err   = 1'b0;
        if (reg_valid) begin
            if (sel_g) begin
                if (reg_size != SZ_HALF) begin
                    reg_err = 1'b1;
                end else if (reg_write) begin
                    st_d.gctl = reg_wdata[GCTL_W-1:0];
                end else begin
                    reg_rdata = {{(DATA_W-GCTL_W){1'b0}}, st_q.gctl};
                end
            end else if (sel_0) begin
                if (reg_write) st_d.cfg0 = reg_wdata;
                else           reg_rdata = st_q.cfg0;
            end else if (sel_1) begin
                if (reg_write) st_d.cfg1 = reg_wdata;
                else           reg_rdata = st_q.cfg1;
            end else begin
                reg_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gctl <= '0;
            st_q.cfg0 <= CFG_RESET;
            st_q.cfg1 <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign field_q = st_q.gctl[CNT_W:1];
    assign en_cnt  = (field_q > CNT_MAX) ? CNT_MAX : field_q;
    assign gctl_o  = st_q.gctl;
    assign cfg0_o  = st_q.cfg0;
    assign cfg1_o  = st_q.cfg1;

    p_gctl_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == OFF_GCTL && reg_size != SZ_HALF)
        |=> $stable(gctl_o));

    p_bad_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_addr != OFF_GCTL && reg_addr != OFF_CFG0 && reg_addr != OFF_CFG1)
        |-> reg_err);

    p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> (reg_rdata == '0));

    p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_valid |-> !reg_err);

    p_cnt_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_cnt <= CNT_MAX);

    p_cfg0_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == OFF_CFG0) |=> (cfg0_o == $past(reg_wdata)));

    p_cfg1_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == OFF_CFG1) |=> (cfg1_o == $past(reg_wdata)));
endmodule

// File: rtl/amem_bank_decode.sv
module amem_bank_decode
    import amem_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] BANK_BASE  = 32'h2000_0000,
    parameter int          BANK_SHIFT = 20,
    parameter int          NUM_BANKS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    mem_addr,
    input  logic [CNT_W-1:0]     en_cnt,
    output logic [NUM_BANKS-1:0] mem_cs
);
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BANK_BASE);

    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] slot;
    logic              in_win;
    logic [IDX_W-1:0]  idx;

    assign offs   = mem_addr - BASE_A;
    assign slot   = offs >> BANK_SHIFT;
    assign in_win = (mem_addr >= BASE_A) && (slot < ADDR_W'(NUM_BANKS));
    assign idx    = slot[IDX_W-1:0];

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        localparam logic [CNT_W-1:0] BI = CNT_W'(i);
        assign mem_cs[i] = in_win && (idx == IDX_W'(i)) && (en_cnt > BI);

        p_cs_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
            mem_cs[i] |-> (en_cnt > BI));
    end

    p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_cs));
endmodule

// File: rtl/amem_bank_ctl.sv
module amem_bank_ctl
    import amem_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] BANK_BASE  = 32'h2000_0000,
    parameter int          BANK_SHIFT = 20,
    parameter int          NUM_BANKS  = 4,
    parameter int          REG_AW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [1:0]           reg_size,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 reg_err,
    input  logic [ADDR_W-1:0]    mem_addr,
    output logic [NUM_BANKS-1:0] mem_cs,
    output logic [15:0]          glb_ctl,
    output logic [31:0]          bank_cfg0,
    output logic [31:0]          bank_cfg1
);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(BANK_BASE);

    logic [CNT_W-1:0] en_cnt;

    amem_regfile #(
        .REG_AW    (REG_AW),
        .NUM_BANKS (NUM_BANKS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_size  (reg_size),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .en_cnt    (en_cnt),
        .gctl_o    (glb_ctl),
        .cfg0_o    (bank_cfg0),
        .cfg1_o    (bank_cfg1)
    );

    amem_bank_decode #(
        .ADDR_W     (ADDR_W),
        .BANK_BASE  (BANK_BASE),
        .BANK_SHIFT (BANK_SHIFT),
        .NUM_BANKS  (NUM_BANKS)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_addr (mem_addr),
        .en_cnt   (en_cnt),
        .mem_cs   (mem_cs)
    );

    p_cs_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_cs) |-> (mem_addr >= WIN_LO));

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_ctl[3:1] == 3'd0) |-> (mem_cs == '0));
endmodule

// File: tb/amem_bank_ctl_tb.sv
module amem_bank_ctl_tb;
    localparam logic [31:0] BASE  = 32'h2000_0000;
    localparam int          SHIFT = 20;
    localparam logic [31:0] BSZ   = 32'h1 << SHIFT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic [31:0] mem_addr = '0;
    logic [3:0]  mem_cs;
    logic [15:0] glb_ctl;
    logic [31:0] bank_cfg0, bank_cfg1;

    int total = 0;
    int bad = 0;
    int live = 0;

    always #2 clk = ~clk;

    amem_bank_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .mem_addr(mem_addr),
        .mem_cs(mem_cs), .glb_ctl(glb_ctl), .bank_cfg0(bank_cfg0), .bank_cfg1(bank_cfg1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output logic e);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = w; reg_addr = a; reg_size = sz; reg_wdata = wd;
        #1;
        rd = reg_rdata; e = reg_err;
        @(posedge clk);
        #1;
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    function automatic logic [3:0] exp_cs(input logic [31:0] a, input int n);
        logic [31:0] o;
        int k;
        if (a < BASE) return 4'b0;
        o = a - BASE;
        k = int'(o >> SHIFT);
        if (o >= 4 * BSZ) return 4'b0;
        if (k >= n) return 4'b0;
        return 4'(1 << k);
    endfunction

    task automatic probe(input string req, input logic [31:0] a, input int n);
        @(negedge clk);
        mem_addr = a;
        #1;
        check(req, {28'b0, mem_cs}, {28'b0, exp_cs(a, n)});
    endtask

    task automatic t_reset();
        logic [31:0] rd; logic e;
        check("R1 glb", {16'b0, glb_ctl}, 32'h0);
        check("R1 cfg0", bank_cfg0, 32'hFFC2_FFC2);
        check("R1 cfg1", bank_cfg1, 32'hFFC2_FFC2);
        probe("R1 no cs", BASE, 0);
        access(1'b0, 8'h0, 2'd1, 32'h0, rd, e);
        check("R1 glb read", rd, 32'h0);
        check("R2 no err", {31'b0, e}, 32'h0);
    endtask

    task automatic t_cfg();
        logic [31:0] rd; logic e;
        access(1'b1, 8'h4, 2'd2, 32'h1234_5678, rd, e);
        check("R9 wr err", {31'b0, e}, 32'h0);
        check("R9 cfg0 out", bank_cfg0, 32'h1234_5678);
        access(1'b0, 8'h4, 2'd0, 32'h0, rd, e);
        check("R2 cfg0 read byte", rd, 32'h1234_5678);
        access(1'b1, 8'h8, 2'd0, 32'hA5A5_0F0F, rd, e);
        check("R9 cfg1 byte write", bank_cfg1, 32'hA5A5_0F0F);
        access(1'b0, 8'h8, 2'd1, 32'h0, rd, e);
        check("R2 cfg1 read", rd, 32'hA5A5_0F0F);
    endtask

    task automatic t_glb_width();
        logic [31:0] rd; logic e;
        access(1'b1, 8'h0, 2'd1, 32'hFFFF_8A5A, rd, e);
        check("R10 glb out", {16'b0, glb_ctl}, 32'h8A5A);
        access(1'b0, 8'h0, 2'd1, 32'h0, rd, e);
        check("R10 glb read", rd, 32'h0000_8A5A);
        access(1'b1, 8'h0, 2'd0, 32'h0000_0008, rd, e);
        check("R3 byte write err", {31'b0, e}, 32'h1);
        access(1'b1, 8'h0, 2'd2, 32'h0000_0008, rd, e);
        check("R3 word write err", {31'b0, e}, 32'h1);
        access(1'b1, 8'h0, 2'd3, 32'h0000_0008, rd, e);
        check("R3 reserved write err", {31'b0, e}, 32'h1);
        check("R3 glb unchanged", {16'b0, glb_ctl}, 32'h8A5A);
        access(1'b0, 8'h0, 2'd2, 32'h0, rd, e);
        check("R3 word read err", {31'b0, e}, 32'h1);
        check("R3 word read zero", rd, 32'h0);
    endtask

    task automatic t_bad_off();
        logic [31:0] rd; logic e;
        logic [7:0] offs[4] = '{8'h2, 8'hC, 8'h10, 8'hFC};
        foreach (offs[j]) begin
            access(1'b1, offs[j], 2'd2, 32'hDEAD_BEEF, rd, e);
            check("R4 bad write err", {31'b0, e}, 32'h1);
            access(1'b0, offs[j], 2'd2, 32'h0, rd, e);
            check("R4 bad read err", {31'b0, e}, 32'h1);
            check("R4 bad read zero", rd, 32'h0);
        end
        check("R4 cfg0 kept", bank_cfg0, 32'h1234_5678);
        check("R4 cfg1 kept", bank_cfg1, 32'hA5A5_0F0F);
        check("R4 glb kept", {16'b0, glb_ctl}, 32'h8A5A);
    endtask

    task automatic t_err_idle();
        @(negedge clk);
        reg_valid = 1'b0; reg_addr = 8'h33; reg_size = 2'd3;
        #1;
        check("R5 idle no err", {31'b0, reg_err}, 32'h0);
        check("R5 idle rdata", reg_rdata, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] rd; logic e;
        for (int f = 0; f < 8; f++) begin
            access(1'b1, 8'h0, 2'd1, 32'((f << 1) | 1 | 16'hF0), rd, e);
            live = (f > 4) ? 4 : f;
            for (int b = 0; b < 4; b++) begin
                probe("R6 R8 count", BASE + 32'(b) * BSZ + 32'h100, live);
            end
        end
    endtask

    task automatic t_decode();
        logic [31:0] rd; logic e;
        access(1'b1, 8'h0, 2'd1, 32'h0000_0008, rd, e);
        probe("R7 below base", BASE - 1, 4);
        probe("R7 base", BASE, 4);
        probe("R7 end bank0", BASE + BSZ - 1, 4);
        probe("R7 start bank1", BASE + BSZ, 4);
        probe("R7 top bank3", BASE + 4 * BSZ - 1, 4);
        probe("R7 past window", BASE + 4 * BSZ, 4);
        probe("R7 far high", 32'hFFFF_FFFF, 4);
        access(1'b1, 8'h0, 2'd1, 32'h0000_0004, rd, e);
        probe("R8 bank2 off", BASE + 2 * BSZ, 2);
        probe("R8 bank1 on", BASE + BSZ + 32'h10, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_glb_width();
        t_bad_off();
        t_err_idle();
        t_enable();
        t_decode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule